// File: doc/BRIEF.md
# Autoincrementing Host Address Generator

This block keeps the running address that a host uses when it reaches into the local processor's memory, and moves that address forward after every completed data transfer. The aim is to stay in step with the address counter inside the local processor's host port. The output is a 32-bit bit address. A 16-bit local memory word therefore spans 16 bit positions, and the four low bits of the address are always zero.

Software sets up three registers through a simple write port: a map register, an extended map register and a control register. In normal mode, the map register picks a 64 Ki-bit segment, and the running address is seeded at the start of that segment. When the extended map register's disable bit is cleared, the map register (upper half) and the extended address field (bits 15..4 of the extended register) form one 28-bit word address. That address seeds a block of autoincremented transfers. A bit in the control register picks the increment step: one 16-bit word or one 32-bit doubleword. The step has to match the prefetch width set in the local processor.

Top module: `haddr_gen`

## Requirements
- R1: While reset is held and after it is released, `host_addr` is 0, extended mapping is off and the step is one word. A transfer straight after reset gives 0x0000_0010.
- R2: A write with `wr_sel`=0 (map) puts `wr_data` into `host_addr[31:16]` from the next clock edge on. In normal mode `host_addr[15:0]` becomes 0.
- R3: A write with `wr_sel`=1 (extended) and `wr_data[0]`=0 turns extended mode on. From the next edge, `host_addr` = {map, `wr_data[15:4]`, 4'b0000}.
- R4: Bits 3..1 of an extended write have no effect, and `host_addr[3:0]` is always 0. An extended write with `wr_data[0]`=1 turns extended mode off and reloads `host_addr` = {map, 16'h0000}.
- R5: With the control step bit at 0, each `xfer_done` pulse adds 16 (one word) to `host_addr`.
- R6: A control write (`wr_sel`=2) stores `wr_data[0]` as the step bit. With the step bit at 1, each `xfer_done` pulse adds 32 (one doubleword).
- R7: A carry out of `host_addr[15:0]` reaches `host_addr[31:16]` in the same clock edge.
- R8: A control write does not change `host_addr`.
- R9: A map or extended write in the same cycle as `xfer_done` reloads the address, and the transfer is ignored.
- R10: Incrementing past 0xFFFF_FFF0 in word mode wraps the address to 0.
- R11: Without a write or a transfer, `host_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 map, 1 extended, 2 control |
| wr_data | input | 16 | Register write data |
| xfer_done | input | 1 | One pulse per completed data transfer |
| host_addr | output | 32 | Running host bit address |

## Verification
The hardest states to reach from the ports are the carry across the 16-bit halves and the 32-bit wrap. Counting transfers up from a segment base would take thousands of pulses to get there. The bench avoids this by using extended mode to seed the address a step or two below each boundary, with a chosen step size, and then sending single transfers. A write that lands in the same cycle as a transfer is also driven on purpose, to show that the reload wins.

// File: rtl/haddr_pkg.sv
package haddr_pkg;
    localparam int HA_HALF_W = 16;
    localparam int HA_WSH    = 4;

    typedef enum logic [1:0] {
        SEL_MAP  = 2'd0,
        SEL_EXT  = 2'd1,
        SEL_CTRL = 2'd2
    } hreg_sel_e;

    function automatic int unsigned step_of(input logic dword, input int wsh);
        return dword ? (32'd2 << wsh) : (32'd1 << wsh);
    endfunction
endpackage

// File: rtl/haddr_regs.sv
module haddr_regs
    import haddr_pkg::*;
#(
    parameter int HALF_W = HA_HALF_W,
    parameter int WSH    = HA_WSH,
    localparam int AW    = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  hreg_sel_e         wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    output logic              reload,
    output logic [AW-1:0]     seed,
    output logic              inc_dword
);
    logic [HALF_W-1:0]   map_q, map_n;
    logic [HALF_W-1:WSH] ext_q, ext_n;
    logic                ext_off_q, ext_off_n;
    logic                dword_q, dword_n;

    always_comb begin
        map_n     = map_q;
        ext_n     = ext_q;
        ext_off_n = ext_off_q;
        dword_n   = dword_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_MAP:  map_n = wr_data;
                SEL_EXT:  begin
                    ext_n     = wr_data[HALF_W-1:WSH];
                    ext_off_n = wr_data[0];
                end
                SEL_CTRL: dword_n = wr_data[0];
                default:  ;
            endcase
        end
    end

    assign reload = wr_en && (wr_sel == SEL_MAP || wr_sel == SEL_EXT);
    assign seed   = ext_off_n ? {map_n, {HALF_W{1'b0}}}
                              : {map_n, ext_n, {WSH{1'b0}}};
    assign inc_dword = dword_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q     <= '0;
            ext_off_q <= 1'b1;
            dword_q   <= 1'b0;
        end else begin
            map_q     <= map_n;
            ext_off_q <= ext_off_n;
            dword_q   <= dword_n;
        end
    end

    always_ff @(posedge clk) begin
        ext_q <= ext_n;
    end
endmodule

// File: rtl/haddr_step.sv
module haddr_step
    import haddr_pkg::*;
#(
    parameter int HALF_W = HA_HALF_W,
    parameter int WSH    = HA_WSH
) (
    input  logic [HALF_W-1:0] lo,
    input  logic [HALF_W-1:0] hi,
    input  logic              dword,
    output logic [HALF_W-1:0] lo_n,
    output logic [HALF_W-1:0] hi_n
);
    logic [HALF_W-1:0] step;
    logic              carry;

    assign step          = HALF_W'(step_of(dword, WSH));
    assign {carry, lo_n} = {1'b0, lo} + {1'b0, step};
    assign hi_n          = hi + {{(HALF_W-1){1'b0}}, carry};
endmodule

// File: rtl/haddr_gen.sv
module haddr_gen
    import haddr_pkg::*;
#(
    parameter int HALF_W = HA_HALF_W,
    parameter int WSH    = HA_WSH,
    localparam int AW    = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              xfer_done,
    output logic [AW-1:0]     host_addr
);
    logic              reload;
    logic [AW-1:0]     seed;
    logic              inc_dword;
    logic [HALF_W-1:0] lo_n, hi_n;
    logic [AW-1:0]     addr_q;

    haddr_regs #(.HALF_W(HALF_W), .WSH(WSH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (hreg_sel_e'(wr_sel)),
        .wr_data   (wr_data),
        .reload    (reload),
        .seed      (seed),
        .inc_dword (inc_dword)
    );

    haddr_step #(.HALF_W(HALF_W), .WSH(WSH)) u_step (
        .lo    (addr_q[HALF_W-1:0]),
        .hi    (addr_q[AW-1:HALF_W]),
        .dword (inc_dword),
        .lo_n  (lo_n),
        .hi_n  (hi_n)
    );

    always_ff @(posedge clk) begin
        if (rst)            addr_q <= '0;
        else if (reload)    addr_q <= seed;
        else if (xfer_done) addr_q <= {hi_n, lo_n};
    end

    assign host_addr = addr_q;
endmodule

// File: rtl/haddr_gen_chk.sv
module haddr_gen_chk #(
    parameter int HALF_W = 16,
    parameter int WSH    = 4,
    localparam int AW    = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [HALF_W-1:0] wr_data,
    input logic              xfer_done,
    input logic [AW-1:0]     host_addr,
    input logic              inc_dword
);
    localparam logic [AW-1:0] WSTEP = AW'(1) << WSH;
    localparam logic [AW-1:0] DSTEP = AW'(2) << WSH;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> host_addr == '0);

    // R2
    map_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> host_addr[AW-1:HALF_W] == $past(wr_data));

    // R4
    aligned_chk: assert property (@(posedge clk) disable iff (rst)
        host_addr[WSH-1:0] == '0);

    // R5
    word_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !wr_en && !inc_dword) |=> host_addr == $past(host_addr) + WSTEP);

    // R6
    dword_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !wr_en && inc_dword) |=> host_addr == $past(host_addr) + DSTEP);

    // R8
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && !xfer_done) |=> $stable(host_addr));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !xfer_done) |=> $stable(host_addr));
endmodule

bind haddr_gen haddr_gen_chk #(.HALF_W(HALF_W), .WSH(WSH)) u_haddr_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .xfer_done (xfer_done),
    .host_addr (host_addr),
    .inc_dword (inc_dword)
);

// File: tb/test_haddr_gen.sv
module test_haddr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic        xfer_done = 1'b0;
    logic [31:0] host_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    haddr_gen i_haddr_gen (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .xfer_done (xfer_done),
        .host_addr (host_addr)
    );

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (host_addr !== exp) begin
            errors++;
            $display("FAIL %s host_addr=%h expected=%h", req, host_addr, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_write(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_xfer(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R1", 32'h0);
        do_xfer(1);
        check("R1", 32'h0000_0010);
    endtask

    task automatic t_map_normal;
        do_write(2'd0, 16'h1234);
        check("R2", 32'h1234_0000);
        do_xfer(3);
        check("R5", 32'h1234_0030);
    endtask

    task automatic t_ext;
        do_write(2'd1, 16'hABC0);
        check("R3", 32'h1234_ABC0);
        do_write(2'd0, 16'h0777);
        check("R2", 32'h0777_ABC0);
    endtask

    task automatic t_reserved;
        do_write(2'd0, 16'h1234);
        do_write(2'd1, 16'h5A7E);
        check("R4", 32'h1234_5A70);
        do_write(2'd1, 16'h9991);
        check("R4", 32'h1234_0000);
    endtask

    task automatic t_dword;
        do_write(2'd1, 16'h0100);
        do_write(2'd2, 16'h0001);
        check("R8", 32'h1234_0100);
        do_xfer(2);
        check("R6", 32'h1234_0140);
    endtask

    task automatic t_carry;
        do_write(2'd1, 16'hFFE0);
        do_xfer(1);
        check("R7", 32'h1235_0000);
        do_write(2'd2, 16'h0000);
        do_write(2'd1, 16'hFFF0);
        do_xfer(1);
        check("R7", 32'h1235_0000);
    endtask

    task automatic t_wrap;
        do_write(2'd0, 16'hFFFF);
        do_write(2'd1, 16'hFFF0);
        check("R10", 32'hFFFF_FFF0);
        do_xfer(1);
        check("R10", 32'h0000_0000);
    endtask

    task automatic t_collide;
        do_write(2'd1, 16'hFFF0);
        xfer_done = 1'b1;
        do_write(2'd0, 16'h0042);
        xfer_done = 1'b0;
        check("R9", 32'h0042_FFF0);
    endtask

    task automatic t_hold;
        repeat (4) @(negedge clk);
        check("R11", 32'h0042_FFF0);
        do_write(2'd2, 16'h0001);
        repeat (2) @(negedge clk);
        check("R11", 32'h0042_FFF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 32'h0);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_map_normal;
        t_ext;
        t_reserved;
        t_dword;
        t_carry;
        t_wrap;
        t_collide;
        t_hold;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule